// File: doc/BRIEF.md
# Nine-Bit Serial Command and Identifier Port

This block connects a host-side request interface to a display controller that takes 9-bit serial words. The first bit of each word on the wire says what kind of byte follows: a command or a parameter. The host asks for a transfer with a valid/ready handshake. Each request carries a command byte and a parameter count, or instead a flag that asks for an identifier read. Parameter bytes are then pulled one at a time through a second handshake, just before each one is shifted out.

On the serial side the block drives an active-low select, a clock and a data output, and it samples a data input. A divider derives the serial clock from the system clock. Each word is framed by its own select pulse, and there is an idle gap between words. An identifier read sends the read-identifier command. It then clocks one full 9-bit dummy word and throws away the input, and finally clocks eight more bits and returns them as the identifier.

Top module: `nine_bit_spi_port`

## Requirements
- R1: Every word sent for a command request is 9 bits, sent most significant bit first. Bit 8 is 0 for the command byte and 1 for a parameter byte. Bits 7..0 carry the byte value.
- R2: A command request sends its command word first and then one word per parameter, in the order the parameters are handed over. A count of zero sends the command word alone.
- R3: The serial clock is low whenever select is high. Data out changes only when the clock falls and holds steady while the clock is high. Data in is captured when the clock rises (mode 0).
- R4: Within a word, consecutive rising clock edges are exactly 2*HALF_DIV system clocks apart, where HALF_DIV = CLK_HZ/(2*SCLK_HZ).
- R5: An identifier read sends 9'h004 as a 9-bit word. It then runs a 9-clock dummy word whose input is ignored, then an 8-clock word. The 8 bits captured in that last word, first bit received as bit 7, appear on id_data.
- R6: Select goes low for each word separately. Between two words of one request it stays high for at least 2*HALF_DIV system clocks.
- R7: busy is high from the cycle after a request is accepted until the last word has finished. done is a single-cycle pulse at completion, busy is low in that cycle, and id_data is valid while done is high.
- R8: req_ready is low while a transfer is in progress. A request offered during that time causes no serial activity and is never performed.
- R9: While reset is asserted, and right after it, select is high, the clock is low, busy and done are low, and req_ready is high. A reset in the middle of a word aborts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be accepted (engine idle) |
| req_read | input | 1 | 1 = identifier read, 0 = command transfer |
| req_cmd | input | 8 | Command byte for a command transfer |
| req_count | input | CNT_W | Number of parameter bytes to follow |
| param_valid | input | 1 | Parameter byte offered |
| param_ready | output | 1 | Engine takes the offered parameter byte |
| param_data | input | 8 | Parameter byte |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| id_data | output | 8 | Identifier captured by the last read |
| cs_n | output | 1 | Serial select, active low |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data to the controller |
| miso | input | 1 | Serial data from the controller |

## Verification
Suppose the word engine's bit counter or shift register goes wrong. The word then closes with the wrong bit count or a bit that has slid out of place, and a serial monitor sees it as soon as select rises at the end of that word. Suppose the sequencer's parameter counter or state goes wrong. The number of select pulses per request is then off, or done never comes. The error is visible within one word time of where the request should have ended. A capture error on the read path shows up as a wrong id_data in the done cycle. The dummy word drives all ones so that a leak from it is easy to see.

// File: rtl/nine_bit_spi_pkg.sv
package nine_bit_spi_pkg;

    localparam int WORD_W = 9;
    localparam int BYTE_W = 8;
    localparam logic [BYTE_W-1:0] READ_ID_OP = 8'h04;

    typedef enum logic [1:0] {
        WE_IDLE,
        WE_SHIFT,
        WE_GAP
    } word_state_e;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_CMD,
        SQ_FETCH,
        SQ_PARAM,
        SQ_DUMMY,
        SQ_IDWORD
    } seq_state_e;

    typedef struct packed {
        word_state_e        st;
        logic [WORD_W-1:0]  sh;
        logic [BYTE_W-1:0]  rx;
        logic [3:0]         left;
        logic               sclk;
        logic               cs_n;
        logic               gap;
        logic               done;
    } word_reg_t;

endpackage

// File: rtl/nine_bit_spi_tick.sv
module nine_bit_spi_tick #(
    parameter int HALF_DIV = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    output logic tick
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    assign tick = (cnt_q == LAST) && !clear;

    always_comb begin
        if (clear || cnt_q == LAST) cnt_d = '0;
        else                        cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/nine_bit_spi_word.sv
module nine_bit_spi_word
    import nine_bit_spi_pkg::*;
#(
    parameter int HALF_DIV = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              start,
    input  logic [WORD_W-1:0] tx_word,
    input  logic              short_word,
    output logic              clr_div,
    output logic              done,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              cs_n,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso
);
    localparam word_reg_t WE_RST = '{st: WE_IDLE, sh: '0, rx: '0, left: '0,
                                     sclk: 1'b0, cs_n: 1'b1, gap: 1'b0, done: 1'b0};

    word_reg_t d, q;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        clr_div = 1'b0;
        case (q.st)
            WE_IDLE: begin
                if (start) begin
                    clr_div = 1'b1;
                    d.st    = WE_SHIFT;
                    d.sh    = tx_word;
                    d.rx    = '0;
                    d.left  = short_word ? 4'd8 : 4'd9;
                    d.cs_n  = 1'b0;
                    d.sclk  = 1'b0;
                end
            end
            WE_SHIFT: begin
                if (tick) begin
                    if (!q.sclk) begin
                        d.sclk = 1'b1;
                        d.rx   = {q.rx[BYTE_W-2:0], miso};
                        d.left = q.left - 4'd1;
                    end else begin
                        d.sclk = 1'b0;
                        if (q.left == 4'd0) begin
                            d.st   = WE_GAP;
                            d.cs_n = 1'b1;
                            d.gap  = 1'b0;
                        end else begin
                            d.sh = {q.sh[WORD_W-2:0], 1'b0};
                        end
                    end
                end
            end
            WE_GAP: begin
                if (tick) begin
                    if (q.gap) begin
                        d.st   = WE_IDLE;
                        d.done = 1'b1;
                    end else begin
                        d.gap = 1'b1;
                    end
                end
            end
            default: d = WE_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= WE_RST;
        else        q <= d;
    end

    assign done    = q.done;
    assign rx_byte = q.rx;
    assign cs_n    = q.cs_n;
    assign sclk    = q.sclk;
    assign mosi    = q.sh[WORD_W-1];

    // checker state: cycles select has been high, saturating
    localparam int GAP_MIN = 2 * HALF_DIV;
    localparam int GW = $clog2(GAP_MIN + 1);
    logic [GW-1:0] hi_cnt_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                         hi_cnt_q <= GW'(GAP_MIN);
        else if (!q.cs_n)                   hi_cnt_q <= '0;
        else if (hi_cnt_q < GW'(GAP_MIN))   hi_cnt_q <= hi_cnt_q + 1'b1;
    end

    assert_clk_idle_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);
    assert_data_hold_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(mosi));
    assert_start_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (q.st == WE_IDLE));
    assert_select_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> (hi_cnt_q >= GW'(GAP_MIN)));
endmodule

// File: rtl/nine_bit_spi_seq.sv
module nine_bit_spi_seq
    import nine_bit_spi_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_read,
    input  logic [BYTE_W-1:0] req_cmd,
    input  logic [CNT_W-1:0]  req_count,
    input  logic              param_valid,
    output logic              param_ready,
    input  logic [BYTE_W-1:0] param_data,
    input  logic              word_done,
    input  logic [BYTE_W-1:0] word_rx,
    output logic              word_start,
    output logic [WORD_W-1:0] word_tx,
    output logic              word_short,
    output logic              busy,
    output logic              done,
    output logic [BYTE_W-1:0] id_data
);
    typedef struct packed {
        seq_state_e         st;
        logic               rd;
        logic [CNT_W-1:0]   remain;
        logic               start;
        logic [WORD_W-1:0]  tx;
        logic               short_w;
        logic               done;
        logic [BYTE_W-1:0]  id;
    } seq_reg_t;

    localparam seq_reg_t SQ_RST = '{st: SQ_IDLE, rd: 1'b0, remain: '0, start: 1'b0,
                                    tx: '0, short_w: 1'b0, done: 1'b0, id: '0};

    seq_reg_t d, q;

    always_comb begin
        d         = q;
        d.start   = 1'b0;
        d.done    = 1'b0;
        req_ready   = (q.st == SQ_IDLE);
        param_ready = (q.st == SQ_FETCH);
        case (q.st)
            SQ_IDLE: begin
                if (req_valid) begin
                    d.st      = SQ_CMD;
                    d.rd      = req_read;
                    d.remain  = req_read ? '0 : req_count;
                    d.tx      = {1'b0, req_read ? READ_ID_OP : req_cmd};
                    d.short_w = 1'b0;
                    d.start   = 1'b1;
                end
            end
            SQ_CMD: begin
                if (word_done) begin
                    if (q.rd) begin
                        d.st    = SQ_DUMMY;
                        d.tx    = '0;
                        d.start = 1'b1;
                    end else if (q.remain == '0) begin
                        d.st   = SQ_IDLE;
                        d.done = 1'b1;
                    end else begin
                        d.st = SQ_FETCH;
                    end
                end
            end
            SQ_FETCH: begin
                if (param_valid) begin
                    d.st     = SQ_PARAM;
                    d.tx     = {1'b1, param_data};
                    d.remain = q.remain - 1'b1;
                    d.start  = 1'b1;
                end
            end
            SQ_PARAM: begin
                if (word_done) begin
                    if (q.remain == '0) begin
                        d.st   = SQ_IDLE;
                        d.done = 1'b1;
                    end else begin
                        d.st = SQ_FETCH;
                    end
                end
            end
            SQ_DUMMY: begin
                if (word_done) begin
                    d.st      = SQ_IDWORD;
                    d.tx      = '0;
                    d.short_w = 1'b1;
                    d.start   = 1'b1;
                end
            end
            SQ_IDWORD: begin
                if (word_done) begin
                    d.st      = SQ_IDLE;
                    d.id      = word_rx;
                    d.short_w = 1'b0;
                    d.done    = 1'b1;
                end
            end
            default: d = SQ_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= SQ_RST;
        else        q <= d;
    end

    assign word_start = q.start;
    assign word_tx    = q.tx;
    assign word_short = q.short_w;
    assign busy       = (q.st != SQ_IDLE);
    assign done       = q.done;
    assign id_data    = q.id;

    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_busy_on_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> busy);
    assert_id_from_last_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == SQ_IDWORD && word_done) |=> (id_data == $past(word_rx)));
endmodule

// File: rtl/nine_bit_spi_port.sv
module nine_bit_spi_port
    import nine_bit_spi_pkg::*;
#(
    parameter int CLK_HZ  = 50_000_000,
    parameter int SCLK_HZ = 1_000_000,
    parameter int CNT_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_read,
    input  logic [7:0]        req_cmd,
    input  logic [CNT_W-1:0]  req_count,
    input  logic              param_valid,
    output logic              param_ready,
    input  logic [7:0]        param_data,
    output logic              busy,
    output logic              done,
    output logic [7:0]        id_data,
    output logic              cs_n,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso
);
    localparam int HALF_RAW = CLK_HZ / (2 * SCLK_HZ);
    localparam int HALF_DIV = (HALF_RAW < 1) ? 1 : HALF_RAW;

    logic              tick, clr_div, word_start, word_short, word_done;
    logic [WORD_W-1:0] word_tx;
    logic [BYTE_W-1:0] word_rx;

    nine_bit_spi_tick #(.HALF_DIV(HALF_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .clear(clr_div), .tick(tick)
    );

    nine_bit_spi_word #(.HALF_DIV(HALF_DIV)) u_word (
        .clk(clk), .rst_n(rst_n), .tick(tick), .start(word_start),
        .tx_word(word_tx), .short_word(word_short), .clr_div(clr_div),
        .done(word_done), .rx_byte(word_rx), .cs_n(cs_n), .sclk(sclk),
        .mosi(mosi), .miso(miso)
    );

    nine_bit_spi_seq #(.CNT_W(CNT_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_read(req_read), .req_cmd(req_cmd), .req_count(req_count),
        .param_valid(param_valid), .param_ready(param_ready),
        .param_data(param_data), .word_done(word_done), .word_rx(word_rx),
        .word_start(word_start), .word_tx(word_tx), .word_short(word_short),
        .busy(busy), .done(done), .id_data(id_data)
    );
endmodule

// File: tb/sim_nine_bit_spi_port.sv
module sim_nine_bit_spi_port;
    localparam int CLK_PERIOD = 20;
    localparam int CLK_HZ  = 50_000_000;
    localparam int SCLK_HZ = 1_000_000;
    localparam int HALF    = CLK_HZ / (2 * SCLK_HZ);
    localparam int NVEC    = 6;

    // {cmd[47:40], count[39:32], p0[31:24], p1, p2, p3[7:0]}
    localparam logic [47:0] VEC [0:NVEC-1] = '{
        {8'h11, 8'd0, 32'h0000_0000},
        {8'h36, 8'd1, 32'h0800_0000},
        {8'hC5, 8'd2, 32'h006A_0000},
        {8'hB1, 8'd3, 32'h0013_1300},
        {8'hE0, 8'd4, 32'hFF00_A55A},
        {8'hFF, 8'd3, 32'h9806_0100}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_read = 1'b0;
    logic [7:0] req_cmd = '0, req_count = '0, param_data = '0;
    logic param_valid = 1'b0;
    logic req_ready, param_ready, busy, done, cs_n, sclk, mosi;
    logic [7:0] id_data;
    logic miso = 1'b0;

    int total = 0, bad = 0, cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nine_bit_spi_port #(.CLK_HZ(CLK_HZ), .SCLK_HZ(SCLK_HZ), .CNT_W(8)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_read(req_read), .req_cmd(req_cmd), .req_count(req_count),
        .param_valid(param_valid), .param_ready(param_ready),
        .param_data(param_data), .busy(busy), .done(done), .id_data(id_data),
        .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .miso(miso)
    );

    // serial monitor and controller model, sampled between edges
    logic [8:0] cur = '0, msh = '0;
    logic [8:0] rec_word [0:15];
    int rec_bits [0:15];
    logic [8:0] mpat [0:2];
    int nb = 0, rec_n = 0, min_gap = 1000000, gap_cnt = 0, per_err = 0;
    int last_rise = 0, mode_err = 0;
    logic prev_sclk = 1'b0, prev_cs = 1'b1, prev_mosi = 1'b0;

    always @(negedge clk) begin
        cyc++;
        if (cs_n && sclk) mode_err++;
        if (prev_sclk && sclk && (mosi !== prev_mosi)) mode_err++;
        if (cs_n) gap_cnt++;
        if (prev_cs && !cs_n) begin
            if (rec_n > 0 && gap_cnt < min_gap) min_gap = gap_cnt;
            gap_cnt = 0;
            cur = '0;
            nb = 0;
            msh = mpat[(rec_n < 3) ? rec_n : 0];
            miso = msh[8];
        end
        if (!cs_n && !prev_sclk && sclk) begin
            if (nb > 0 && (cyc - last_rise) != 2 * HALF) per_err++;
            last_rise = cyc;
            cur = {cur[7:0], mosi};
            nb++;
        end
        if (!cs_n && prev_sclk && !sclk) begin
            msh = {msh[7:0], 1'b0};
            miso = msh[8];
        end
        if (!prev_cs && cs_n && rec_n < 16) begin
            rec_word[rec_n] = cur;
            rec_bits[rec_n] = nb;
            rec_n++;
        end
        prev_sclk = sclk;
        prev_cs   = cs_n;
        prev_mosi = mosi;
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clear_mon();
        rec_n = 0; min_gap = 1000000; per_err = 0; mode_err = 0;
    endtask

    task automatic issue(input logic rd, input logic [7:0] cmd, input logic [7:0] cnt);
        @(negedge clk);
        req_valid = 1'b1; req_read = rd; req_cmd = cmd; req_count = cnt;
        @(negedge clk);
        req_valid = 1'b0;
        check(busy === 1'b1, "R7 busy after accept", 32'(busy), 32'd1);
        check(req_ready === 1'b0, "R8 ready low while busy", 32'(req_ready), 32'd0);
    endtask

    task automatic feed(input logic [7:0] cnt, input logic [31:0] p);
        for (int k = 0; k < cnt; k++) begin
            param_valid = 1'b1;
            param_data  = p[31 - 8*k -: 8];
            forever begin
                @(negedge clk);
                if (param_ready) break;
            end
            @(negedge clk);
        end
        param_valid = 1'b0;
    endtask

    task automatic wait_done(input string tag);
        int n = 0;
        while (!done && n < 20000) begin
            @(negedge clk);
            n++;
        end
        check(done === 1'b1, tag, 32'(done), 32'd1);
        check(busy === 1'b0, "R7 busy low with done", 32'(busy), 32'd0);
    endtask

    task automatic do_write(input logic [7:0] cmd, input logic [7:0] cnt,
                            input logic [31:0] p);
        clear_mon();
        issue(1'b0, cmd, cnt);
        feed(cnt, p);
        wait_done("R7 done after command");
        @(negedge clk);
        check(done === 1'b0, "R7 done single cycle", 32'(done), 32'd0);
        check(rec_n == int'(cnt) + 1, "R2 word count", 32'(rec_n), 32'(cnt) + 1);
        check(rec_word[0] == {1'b0, cmd} && rec_bits[0] == 9, "R1 command word",
              {rec_bits[0][7:0], 15'd0, rec_word[0]}, {8'd9, 15'd0, 1'b0, cmd});
        for (int k = 0; k < cnt; k++)
            check(rec_word[k+1] == {1'b1, p[31 - 8*k -: 8]} && rec_bits[k+1] == 9,
                  "R1 R2 parameter word", 32'(rec_word[k+1]),
                  32'({1'b1, p[31 - 8*k -: 8]}));
        check(per_err == 0, "R4 clock period", 32'(per_err), 32'd0);
        check(mode_err == 0, "R3 mode 0 timing", 32'(mode_err), 32'd0);
        if (cnt > 0)
            check(min_gap >= 2 * HALF, "R6 select gap", 32'(min_gap), 32'(2 * HALF));
    endtask

    task automatic do_read(input logic [7:0] id);
        clear_mon();
        mpat[0] = 9'h000; mpat[1] = 9'h1FF; mpat[2] = {id, 1'b0};
        issue(1'b1, 8'h00, 8'd0);
        wait_done("R7 done after read");
        check(id_data == id, "R5 identifier value", 32'(id_data), 32'(id));
        check(rec_n == 3, "R5 read word count", 32'(rec_n), 32'd3);
        check(rec_word[0] == 9'h004 && rec_bits[0] == 9, "R5 read opcode word",
              32'(rec_word[0]), 32'h004);
        check(rec_bits[1] == 9, "R5 dummy word length", 32'(rec_bits[1]), 32'd9);
        check(rec_bits[2] == 8, "R5 capture word length", 32'(rec_bits[2]), 32'd8);
        check(min_gap >= 2 * HALF, "R6 select gap on read", 32'(min_gap), 32'(2 * HALF));
        check(per_err == 0 && mode_err == 0, "R3 R4 read timing",
              32'(per_err + mode_err), 32'd0);
    endtask

    initial begin
        while (cyc < 190000) @(negedge clk);
        check(1'b0, "watchdog expired", 32'(cyc), 32'd0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        mpat[0] = '0; mpat[1] = '0; mpat[2] = '0;
        repeat (3) @(negedge clk);
        check(cs_n === 1'b1 && sclk === 1'b0, "R9 serial idle in reset",
              {30'd0, cs_n, sclk}, 32'd2);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready === 1'b1 && busy === 1'b0 && done === 1'b0, "R9 host idle",
              {29'd0, req_ready, busy, done}, 32'd4);
        check(param_ready === 1'b0, "R9 no parameter pull", 32'(param_ready), 32'd0);

        // table walk
        for (int v = 0; v < NVEC; v++)
            do_write(VEC[v][47:40], VEC[v][39:32], VEC[v][31:0]);

        // identifier reads
        do_read(8'h80);
        do_read(8'h5A);

        // requests offered while busy are ignored
        clear_mon();
        issue(1'b0, 8'h29, 8'd1);
        req_valid = 1'b1; req_read = 1'b1; req_cmd = 8'h3A; req_count = 8'd2;
        feed(8'd1, 32'h5500_0000);
        begin
            int hi = 0;
            repeat (200) begin
                @(negedge clk);
                if (req_ready) hi++;
            end
            check(hi == 0, "R8 ready held low", 32'(hi), 32'd0);
        end
        req_valid = 1'b0;
        wait_done("R8 first request completes");
        repeat (1500) @(negedge clk);
        check(rec_n == 2, "R8 no extra words", 32'(rec_n), 32'd2);
        check(rec_word[1] == 9'h155, "R8 only original parameter",
              32'(rec_word[1]), 32'h155);
        check(busy === 1'b0, "R8 no second transfer", 32'(busy), 32'd0);

        // reset in the middle of a word
        clear_mon();
        issue(1'b0, 8'hB6, 8'd2);
        repeat (120) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(cs_n === 1'b1 && sclk === 1'b0 && busy === 1'b0, "R9 abort on reset",
              {29'd0, cs_n, sclk, busy}, 32'd4);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check(req_ready === 1'b1, "R9 ready after reset", 32'(req_ready), 32'd1);
        do_write(8'h3A, 8'd1, 32'h6600_0000);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule